// File: doc/BRIEF.md
# Byte-Register Window to Wishbone Master Bridge

This block lets a host that can only read and write 8-bit registers drive single 32-bit Wishbone classic bus cycles. The host fills four address bytes and four data bytes, then writes a code to a command register. The bridge runs one cycle on the bus and stores any returned word back into the data bytes, where the host reads it out a byte at a time.

The command register also acts as the status register. On a read it shows a sticky bus-error flag, a sticky interrupt flag and a busy bit. Writing it with the top bit set clears both flags and starts no cycle. If a bus cycle gets neither an acknowledge nor an error, a timeout counter ends it and records an error.

Top module: `regwin_wb_bridge`

## Requirements
- R1: After reset, byte indices 0 to 7 and the command index 16 read zero, and wb_cyc and wb_stb are low.
- R2: Byte indices 0..3 form the bus address with index 0 as bits 31:24 and index 3 as bits 7:0. This address drives wb_adr during a cycle.
- R3: Writing 0x03 to index 16 while idle starts a write cycle on the next clock. wb_cyc, wb_stb and wb_we are high, wb_sel is 4'hF, and wb_dat_o carries byte indices 4..7, with index 4 as bits 31:24.
- R4: Writing 0x01 to index 16 while idle starts a read cycle on the next clock with wb_we low. wb_cyc and wb_stb stay high until the clock that samples wb_ack or wb_err, and they are low on the clock after it.
- R5: On an acknowledged read, wb_dat_i is stored into byte indices 4..7, bits 31:24 into index 4. A read that ends with wb_err or a timeout leaves those bytes unchanged.
- R6: A command write with any value other than 0x01 or 0x03 starts no cycle. A command write made while a cycle is in progress is also ignored.
- R7: Status bit 0 (error) at index 16 sets when a cycle ends with wb_err. It stays set until it is cleared.
- R8: A cycle that gets no wb_ack or wb_err ends after TIMEOUT_CYCLES clocks with wb_cyc high, and it sets the error bit.
- R9: Status bit 1 (interrupt) at index 16 sets on any clock that samples irq_in high. It stays set until it is cleared.
- R10: Writing index 16 with bit 7 set clears both flags and starts no cycle. A flag-setting event on the same clock takes priority over the clear.
- R11: Status bit 2 (busy) at index 16 is high exactly while wb_cyc is high.
- R12: Reads of indices other than 0..7 and 16 return zero. Writes to those indices change no register.
- R13: Address and write data are captured when a cycle starts. Host writes to indices 0..7 during a cycle do not change wb_adr or wb_dat_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register index |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Readback of the byte at host_addr (combinational) |
| irq_in | input | 1 | Interrupt request input |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_sel | output | 4 | Wishbone byte selects |
| wb_adr | output | 32 | Wishbone address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_ack | input | 1 | Wishbone acknowledge |
| wb_err | input | 1 | Wishbone error |

## Verification
A command write sampled on clock k raises wb_cyc and the busy bit after that same edge. A response sampled on clock m clears them and updates the data bytes and the error flag after edge m. The timeout ends a silent cycle after exactly TIMEOUT_CYCLES clocks with wb_cyc high. The bench drives inputs on falling edges and checks each result at the falling edge that follows the rising edge that produces it. Readback is combinational, so it is sampled shortly after host_addr changes, with no clock edge in between.

// File: rtl/regwin_pkg.sv
// Shared constants and types for the byte-register window bridge.
// Assumes an 8-bit host register index space.
package regwin_pkg;
    localparam int unsigned IDX_W      = 8;
    localparam logic [7:0]  CMD_IDX    = 8'd16;
    localparam logic [7:0]  CODE_READ  = 8'h01;
    localparam logic [7:0]  CODE_WRITE = 8'h03;
    localparam int unsigned CLEAR_BIT  = 7;
    localparam int unsigned ST_ERR     = 0;
    localparam int unsigned ST_IRQ     = 1;
    localparam int unsigned ST_BUSY    = 2;

    typedef enum logic {BUS_IDLE, BUS_ACTIVE} bus_state_t;
endpackage

// File: rtl/regwin_regfile.sv
// Address and data byte registers plus the readback multiplexer.
// Assumes the command index lies above the byte registers.
module regwin_regfile
    import regwin_pkg::*;
#(
    parameter int unsigned ADR_BYTES = 4,
    parameter int unsigned DAT_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_byte,
    input  logic                   load_en,
    input  logic [8*DAT_BYTES-1:0] load_word,
    input  logic [IDX_W-1:0]       rd_idx,
    input  logic [7:0]             status_byte,
    output logic [7:0]             rd_byte,
    output logic [8*ADR_BYTES-1:0] adr_word,
    output logic [8*DAT_BYTES-1:0] dat_word
);
    localparam int unsigned NREG = ADR_BYTES + DAT_BYTES;

    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g < ADR_BYTES) begin : g_adr
            // Address byte: written only by the host.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (wr_en && wr_idx == IDX_W'(g))
                    regs[g] <= wr_byte;
            end
            assign adr_word[8*(ADR_BYTES-1-g) +: 8] = regs[g];
        end else begin : g_dat
            // Data byte: a completed bus read takes priority over a host write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (load_en)
                    regs[g] <= load_word[8*(NREG-1-g) +: 8];
                else if (wr_en && wr_idx == IDX_W'(g))
                    regs[g] <= wr_byte;
            end
            assign dat_word[8*(NREG-1-g) +: 8] = regs[g];
        end
    end

    // Readback: byte registers, status at the command index, zero elsewhere.
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == IDX_W'(i))
                rd_byte = regs[i];
        if (rd_idx == CMD_IDX)
            rd_byte = status_byte;
    end
endmodule

// File: rtl/regwin_wb_master.sv
// Single-cycle Wishbone classic master with a timeout.
// Captures address and data at start and holds CYC/STB until ACK, ERR or the timeout.
module regwin_wb_master
    import regwin_pkg::*;
#(
    parameter int unsigned AW  = 32,
    parameter int unsigned DW  = 32,
    parameter int unsigned TMO = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_we,
    input  logic [AW-1:0] adr_in,
    input  logic [DW-1:0] dat_in,
    output logic          wb_cyc,
    output logic          wb_stb,
    output logic          wb_we,
    output logic [DW/8-1:0] wb_sel,
    output logic [AW-1:0] wb_adr,
    output logic [DW-1:0] wb_dat_o,
    input  logic          wb_ack,
    input  logic          wb_err,
    output logic          rd_done,
    output logic          err_evt,
    output logic          busy
);
    localparam int unsigned CW = (TMO > 2) ? $clog2(TMO) : 1;

    bus_state_t    state_q;
    logic          we_q;
    logic [AW-1:0] adr_q;
    logic [DW-1:0] dat_q;
    logic [CW-1:0] cnt_q;
    logic          active, expired, finish;

    assign active  = (state_q == BUS_ACTIVE);
    assign expired = (cnt_q == CW'(TMO-1));
    assign finish  = active && (wb_ack || wb_err || expired);

    // Cycle sequencer: start, count wait clocks, terminate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            we_q    <= 1'b0;
            adr_q   <= '0;
            dat_q   <= '0;
            cnt_q   <= '0;
        end else if (!active) begin
            if (start) begin
                state_q <= BUS_ACTIVE;
                we_q    <= start_we;
                adr_q   <= adr_in;
                dat_q   <= dat_in;
                cnt_q   <= '0;
            end
        end else if (finish) begin
            state_q <= BUS_IDLE;
            we_q    <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wb_cyc   = active;
    assign wb_stb   = active;
    assign wb_we    = we_q;
    assign wb_sel   = {(DW/8){active}};
    assign wb_adr   = adr_q;
    assign wb_dat_o = dat_q;
    assign busy     = active;
    assign rd_done  = active && !we_q && wb_ack && !wb_err;
    assign err_evt  = active && (wb_err || (!wb_ack && expired));
endmodule

// File: rtl/regwin_flags.sv
// Sticky error and interrupt flags; a set event wins over a same-clock clear.
module regwin_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic err_set,
    input  logic irq_set,
    input  logic clr,
    output logic err_flag,
    output logic irq_flag
);
    // Error flag: set on bus error or timeout, cleared by host.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_flag <= 1'b0;
        else if (err_set) err_flag <= 1'b1;
        else if (clr)     err_flag <= 1'b0;
    end

    // Interrupt flag: set while irq input is high, cleared by host.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_flag <= 1'b0;
        else if (irq_set) irq_flag <= 1'b1;
        else if (clr)     irq_flag <= 1'b0;
    end
endmodule

// File: rtl/regwin_wb_bridge.sv
// Top: host byte-register window that issues single Wishbone cycles.
// Assumes one host access per clock, readback is combinational on host_addr.
module regwin_wb_bridge
    import regwin_pkg::*;
#(
    parameter int unsigned ADR_BYTES      = 4,
    parameter int unsigned DAT_BYTES      = 4,
    parameter int unsigned TIMEOUT_CYCLES = 1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_we,
    input  logic [7:0]             host_addr,
    input  logic [7:0]             host_wdata,
    output logic [7:0]             host_rdata,
    input  logic                   irq_in,
    output logic                   wb_cyc,
    output logic                   wb_stb,
    output logic                   wb_we,
    output logic [DAT_BYTES-1:0]   wb_sel,
    output logic [8*ADR_BYTES-1:0] wb_adr,
    output logic [8*DAT_BYTES-1:0] wb_dat_o,
    input  logic [8*DAT_BYTES-1:0] wb_dat_i,
    input  logic                   wb_ack,
    input  logic                   wb_err
);
    localparam int unsigned AW   = 8 * ADR_BYTES;
    localparam int unsigned DW   = 8 * DAT_BYTES;
    localparam int unsigned NREG = ADR_BYTES + DAT_BYTES;

    logic          cmd_wr, byte_wr, start, start_we, clr;
    logic          rd_done, err_evt, busy, err_flag, irq_flag;
    logic [AW-1:0] adr_word;
    logic [DW-1:0] dat_word;
    logic [7:0]    status_byte;

    // Host write decode: byte registers, command start, flag clear.
    assign cmd_wr   = host_we && (host_addr == CMD_IDX);
    assign byte_wr  = host_we && (host_addr < 8'(NREG));
    assign clr      = cmd_wr && host_wdata[CLEAR_BIT];
    assign start    = cmd_wr && !busy &&
                      (host_wdata == CODE_READ || host_wdata == CODE_WRITE);
    assign start_we = (host_wdata == CODE_WRITE);

    // Status byte layout for the command index.
    always_comb begin
        status_byte          = '0;
        status_byte[ST_ERR]  = err_flag;
        status_byte[ST_IRQ]  = irq_flag;
        status_byte[ST_BUSY] = busy;
    end

    regwin_regfile #(.ADR_BYTES(ADR_BYTES), .DAT_BYTES(DAT_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(byte_wr), .wr_idx(host_addr), .wr_byte(host_wdata),
        .load_en(rd_done), .load_word(wb_dat_i),
        .rd_idx(host_addr), .status_byte(status_byte), .rd_byte(host_rdata),
        .adr_word(adr_word), .dat_word(dat_word)
    );

    regwin_wb_master #(.AW(AW), .DW(DW), .TMO(TIMEOUT_CYCLES)) u_master (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_we(start_we), .adr_in(adr_word), .dat_in(dat_word),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_sel(wb_sel),
        .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_ack(wb_ack), .wb_err(wb_err),
        .rd_done(rd_done), .err_evt(err_evt), .busy(busy)
    );

    regwin_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .err_set(err_evt), .irq_set(irq_in), .clr(clr),
        .err_flag(err_flag), .irq_flag(irq_flag)
    );
endmodule

// File: rtl/regwin_wb_bridge_chk.sv
// Checker for the bridge: bus holding, timeout bound, flag and busy behaviour.
module regwin_wb_bridge_chk #(
    parameter int unsigned AW  = 32,
    parameter int unsigned DW  = 32,
    parameter int unsigned TMO = 1024
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_we,
    input logic [7:0]    host_addr,
    input logic [7:0]    host_wdata,
    input logic [7:0]    host_rdata,
    input logic          irq_in,
    input logic          wb_cyc,
    input logic          wb_we,
    input logic [AW-1:0] wb_adr,
    input logic [DW-1:0] wb_dat_o,
    input logic          wb_ack,
    input logic          wb_err,
    input logic          err_flag,
    input logic          irq_flag
);
    localparam int unsigned CW = $clog2(TMO + 1);
    logic [CW-1:0] cnt_q;

    // Independent count of clocks the cycle has been open before this one.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wb_cyc) cnt_q <= cnt_q + 1'b1;
        else             cnt_q <= '0;
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc && !wb_ack && !wb_err && cnt_q != CW'(TMO-1) |=> wb_cyc);
    p_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc && (wb_ack || wb_err) |=> !wb_cyc);
    p_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc && !wb_ack && !wb_err && cnt_q != CW'(TMO-1)
        |=> $stable(wb_adr) && $stable(wb_dat_o) && $stable(wb_we));
    p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc |-> cnt_q < CW'(TMO));
    p_tmo_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc && cnt_q == CW'(TMO-1) |=> err_flag);
    p_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc && wb_err |=> err_flag);
    p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in |=> irq_flag);
    p_badcode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_cyc && host_we && host_addr == 8'd16 &&
        host_wdata != 8'h01 && host_wdata != 8'h03 |=> !wb_cyc);
    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr == 8'd16 |-> host_rdata[2] == wb_cyc);
endmodule

bind regwin_wb_bridge regwin_wb_bridge_chk #(
    .AW(8*ADR_BYTES), .DW(8*DAT_BYTES), .TMO(TIMEOUT_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_in(irq_in),
    .wb_cyc(wb_cyc), .wb_we(wb_we), .wb_adr(wb_adr), .wb_dat_o(wb_dat_o),
    .wb_ack(wb_ack), .wb_err(wb_err), .err_flag(err_flag), .irq_flag(irq_flag)
);

// File: tb/regwin_wb_bridge_bench.sv
// Self-checking bench: sweeps byte indices, command codes and response latencies.
module regwin_wb_bridge_bench;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        irq_in = 1'b0;
    logic        wb_cyc, wb_stb, wb_we;
    logic [3:0]  wb_sel;
    logic [31:0] wb_adr, wb_dat_o;
    logic [31:0] wb_dat_i = '0;
    logic        wb_ack = 1'b0;
    logic        wb_err = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    regwin_wb_bridge #(.TIMEOUT_CYCLES(TMO)) u_regwin_wb_bridge (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_in(irq_in),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_sel(wb_sel),
        .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
        .wb_ack(wb_ack), .wb_err(wb_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Host write; returns at the falling edge after the sampling rising edge.
    task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic load_word(input logic [7:0] base, input logic [31:0] w);
        for (int i = 0; i < 4; i++) hwrite(base + 8'(i), w[8*(3-i) +: 8]);
    endtask

    task automatic read_word(input logic [7:0] base, output logic [31:0] w);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            hread(base + 8'(i), b);
            w[8*(3-i) +: 8] = b;
        end
    endtask

    // Respond to an open cycle after lat waiting clocks with ack or err.
    task automatic respond(input int lat, input bit use_err, input logic [31:0] rd);
        for (int i = 0; i < lat; i++) begin
            check("R4 cyc held", {30'd0, wb_cyc, wb_stb}, 32'd3);
            @(negedge clk);
        end
        wb_ack = !use_err; wb_err = use_err; wb_dat_i = rd;
        @(negedge clk);
        wb_ack = 1'b0; wb_err = 1'b0;
        check("R4 cyc ends", {31'd0, wb_cyc}, 32'd0);
    endtask

    initial begin
        logic [7:0]  b;
        logic [31:0] w, a, d, keep;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 8; i++) begin hread(8'(i), b); check("R1 byte", {24'd0, b}, 32'd0); end
        hread(8'd16, b); check("R1 status", {24'd0, b}, 32'd0);
        check("R1 cyc", {31'd0, wb_cyc}, 32'd0);

        // R2/R5/R4: reads over several latencies and patterns
        for (int lat = 0; lat < 5; lat++) begin
            a = 32'hA5C3_0F18 ^ (32'h0101_0101 * lat);
            d = ~a + 32'(lat);
            load_word(8'd0, a);
            read_word(8'd0, w); check("R2 addr bytes", w, a);
            hwrite(8'd16, 8'h01);
            check("R4 start", {29'd0, wb_cyc, wb_stb, wb_we}, 32'd6);
            check("R2 wb_adr", wb_adr, a);
            hread(8'd16, b); check("R11 busy high", {29'd0, b[2:0]}, 32'd4);
            respond(lat, 1'b0, d);
            read_word(8'd4, w); check("R5 read data", w, d);
            hread(8'd16, b); check("R11 busy low", {24'd0, b}, 32'd0);
        end

        // R3: writes over several latencies
        for (int lat = 0; lat < 4; lat++) begin
            a = 32'h1234_5678 + 32'(lat * 4);
            d = 32'hDEAD_0000 | 32'(lat * 32'h111);
            load_word(8'd0, a);
            load_word(8'd4, d);
            hwrite(8'd16, 8'h03);
            check("R3 start we", {30'd0, wb_cyc, wb_we}, 32'd3);
            check("R3 sel", {28'd0, wb_sel}, 32'hF);
            check("R3 adr", wb_adr, a);
            check("R3 dat_o", wb_dat_o, d);
            respond(lat, 1'b0, 32'hFFFF_FFFF);
            read_word(8'd4, w); check("R3 data kept after write", w, d);
        end

        // R13 and R6 (busy): writes during a cycle
        a = 32'h0BAD_F00D;
        load_word(8'd0, a);
        hwrite(8'd16, 8'h01);
        hwrite(8'd0, 8'h77);
        hwrite(8'd16, 8'h03);
        check("R13 adr stable", wb_adr, a);
        check("R6 busy cmd ignored we", {31'd0, wb_we}, 32'd0);
        respond(0, 1'b0, 32'h0102_0304);
        @(negedge clk);
        check("R6 no restart", {31'd0, wb_cyc}, 32'd0);
        hread(8'd0, b); check("R13 host byte accepted", {24'd0, b}, 32'h77);

        // R7/R5: error response leaves data, sets sticky flag
        read_word(8'd4, keep);
        hwrite(8'd16, 8'h01);
        respond(2, 1'b1, 32'h5555_AAAA);
        read_word(8'd4, w); check("R5 err keeps data", w, keep);
        repeat (3) @(negedge clk);
        hread(8'd16, b); check("R7 err sticky", {24'd0, b}, 32'h01);
        hwrite(8'd16, 8'h80);
        hread(8'd16, b); check("R10 clear", {24'd0, b}, 32'h00);
        check("R10 no cycle", {31'd0, wb_cyc}, 32'd0);

        // R8: timeout
        hwrite(8'd16, 8'h01);
        n = 0;
        while (wb_cyc && n < 4 * TMO) begin n++; @(negedge clk); end
        check("R8 timeout length", 32'(n), 32'(TMO));
        hread(8'd16, b); check("R8 timeout err", {24'd0, b}, 32'h01);
        read_word(8'd4, w); check("R5 timeout keeps data", w, keep);
        hwrite(8'd16, 8'h80);

        // R9/R10: interrupt flag, clear, and same-clock priority
        @(negedge clk); irq_in = 1'b1; @(negedge clk); irq_in = 1'b0;
        repeat (2) @(negedge clk);
        hread(8'd16, b); check("R9 irq sticky", {24'd0, b}, 32'h02);
        @(negedge clk);
        host_we = 1'b1; host_addr = 8'd16; host_wdata = 8'h80; irq_in = 1'b1;
        @(negedge clk);
        host_we = 1'b0; irq_in = 1'b0;
        hread(8'd16, b); check("R10 set wins", {24'd0, b}, 32'h02);
        hwrite(8'd16, 8'h80);
        hread(8'd16, b); check("R10 cleared", {24'd0, b}, 32'h00);

        // R6/R10: sweep of every command value
        for (int v = 0; v < 256; v++) begin
            @(negedge clk); irq_in = 1'b1; @(negedge clk); irq_in = 1'b0;
            hwrite(8'd16, 8'(v));
            check("R6 start only on 1 or 3", {31'd0, wb_cyc},
                  (v == 1 || v == 3) ? 32'd1 : 32'd0);
            if (wb_cyc) respond(0, 1'b0, 32'h0);
            hread(8'd16, b);
            check("R10 clear by bit7", {31'd0, b[1]}, (v >= 128) ? 32'd0 : 32'd1);
        end
        hwrite(8'd16, 8'h80);

        // R12: unmapped indices
        load_word(8'd0, 32'h0011_2233);
        load_word(8'd4, 32'h4455_6677);
        for (int i = 8; i < 256; i++) begin
            if (i == 16) continue;
            hwrite(8'(i), 8'hFF);
            hread(8'(i), b); check("R12 unmapped zero", {24'd0, b}, 32'd0);
        end
        read_word(8'd0, w); check("R12 addr untouched", w, 32'h0011_2233);
        read_word(8'd4, w); check("R12 data untouched", w, 32'h4455_6677);
        check("R12 no cycle", {31'd0, wb_cyc}, 32'd0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule